// File: doc/BRIEF.md
# GPE Status/Enable Register Bank with SCI Level Generator

This block holds the general-purpose event bytes of a power-management controller: a bank of status bytes that hardware events set and software clears, next to a bank of enable bytes that software owns. Two hotplug sources, one for PCI slots and one for processors, each pulse a single status bit. A byte-addressed request port lets software read the whole window and write it in accesses of one to four bytes.

The block also forms the system control interrupt level. The SCI is the OR of two qualified groups. The first group is the PM1 event status and enable vectors, which come from outside and are masked down to four sources. The second group is GPE status byte 0 masked by enable byte 0, where only the two hotplug bits count. A second output asks the external PM timer to arm itself while its enable is set and its status has not yet fired.

Top module: `gpe_sci_regs`

## Requirements
- R1: Reset clears every status and enable byte, so the whole window reads zero and `sci` is low.
- R2: The window is GPE_BYTES bytes long (default 4). Offsets 0 to GPE_BYTES/2-1 are status bytes and the offsets above them are enable bytes. Byte lanes whose address falls past the window read as zero, and writes to them are ignored.
- R3: `req_len` holds the byte count minus one. Lane k (bits 8k+7:8k of `req_wdata`/`req_rdata`) maps to address `req_addr`+k, so multi-byte accesses are little-endian. Lanes with k greater than `req_len` are untouched and read zero. Read data is valid in the same cycle as a read request.
- R4: A `pci_hp_evt` pulse sets status byte 0 bit 1, and a `cpu_hp_evt` pulse sets status byte 0 bit 2, both at the next clock edge. No other status bit is ever set.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: Enable bytes are plain read/write storage and change only when written.
- R7: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `sci` is high whenever status byte 0 AND enable byte 0 has bit 1 or bit 2 set. Other enable bits add nothing. The level follows the cycle after a write or event.
- R9: `sci` is high whenever `pm1_sts` AND `pm1_en` is non-zero in bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). The other PM1 bits never raise it.
- R10: `tmr_arm` is high exactly when `pm1_en` bit 0 is set and `pm1_sts` bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(GPE_BYTES) | Start byte address in the window |
| req_len | input | $clog2(LANES) | Byte count minus one |
| req_wdata | input | 8*LANES | Write data, lane k for address req_addr+k |
| req_rdata | output | 8*LANES | Read data, same lane mapping |
| pci_hp_evt | input | 1 | PCI hotplug event pulse |
| cpu_hp_evt | input | 1 | Processor hotplug event pulse |
| pm1_sts | input | 16 | PM1 event status vector |
| pm1_en | input | 16 | PM1 event enable vector |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Request to arm the PM timer |

## Verification
The bench builds the block with its defaults: a four-byte window and four lanes. With these values every pairing of start address and length, sixteen in all, can be written and read against a byte model. Enable byte 0 is swept over all 256 values under each of the four hotplug status patterns, which covers the whole GPE side of the interrupt. The sixteen-bit PM1 side is covered by every pairing of one status bit with one enable bit, plus the four timer-bit combinations.

// File: rtl/gpe_sci_regs.sv
module gpe_sci_regs #(
  parameter int          GPE_BYTES    = 4,
  parameter int          LANES        = 4,
  parameter logic [15:0] PM1_SCI_MASK = 16'h0521,
  parameter int          PM1_TMR_BIT  = 0,
  parameter int          PCI_BIT      = 1,
  parameter int          CPU_BIT      = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [$clog2(GPE_BYTES)-1:0] req_addr,
  input  logic [$clog2(LANES)-1:0]     req_len,
  input  logic [8*LANES-1:0]           req_wdata,
  output logic [8*LANES-1:0]           req_rdata,
  input  logic                         pci_hp_evt,
  input  logic                         cpu_hp_evt,
  input  logic [15:0]                  pm1_sts,
  input  logic [15:0]                  pm1_en,
  output logic                         sci,
  output logic                         tmr_arm
);
  localparam int HALF = GPE_BYTES / 2;
  localparam int AW   = $clog2(GPE_BYTES);
  localparam int LW   = $clog2(LANES);
  localparam int SW   = 8 * HALF;
  localparam int EAW  = AW + LW + 1;
  localparam logic [7:0] HP_MASK = 8'((1 << PCI_BIT) | (1 << CPU_BIT));

  logic [SW-1:0]          sts_q, en_q, clr, en_d, set_v;
  logic [2*SW-1:0]        win;
  logic [LANES-1:0]       lane_on;
  logic [LANES-1:0][EAW-1:0] lane_a;

  assign win = {en_q, sts_q};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_a[k]  = EAW'(req_addr) + EAW'(k);
    assign lane_on[k] = req_valid && (k <= int'(req_len)) && (int'(lane_a[k]) < GPE_BYTES);
  end

  always_comb begin
    clr       = '0;
    en_d      = en_q;
    req_rdata = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_on[k]) begin
        if (req_write) begin
          if (int'(lane_a[k]) < HALF)
            clr[int'(lane_a[k])*8 +: 8] = req_wdata[k*8 +: 8];
          else
            en_d[(int'(lane_a[k]) - HALF)*8 +: 8] = req_wdata[k*8 +: 8];
        end else begin
          req_rdata[k*8 +: 8] = win[int'(lane_a[k])*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    set_v          = '0;
    set_v[PCI_BIT] = pci_hp_evt;
    set_v[CPU_BIT] = cpu_hp_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr) | set_v;
      en_q  <= en_d;
    end
  end

  assign sci     = (|(pm1_sts & pm1_en & PM1_SCI_MASK)) ||
                   (|(sts_q[7:0] & en_q[7:0] & HP_MASK));
  assign tmr_arm = pm1_en[PM1_TMR_BIT] && !pm1_sts[PM1_TMR_BIT];
endmodule

// File: rtl/gpe_sci_regs_chk.sv
module gpe_sci_regs_chk #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          pci_hp_evt,
  input logic          cpu_hp_evt,
  input logic [15:0]   pm1_sts,
  input logic [15:0]   pm1_en,
  input logic          sci,
  input logic          tmr_arm,
  input logic [SW-1:0] sts_q,
  input logic [SW-1:0] en_q
);
  a_r4_pci_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pci_hp_evt |=> sts_q[1]);
  a_r4_cpu_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hp_evt |=> sts_q[2]);
  a_r4_only_hp_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~SW'(8'h06)) == '0);
  a_r5_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_hp_evt && !cpu_hp_evt && !(req_valid && req_write)) |=> $stable(sts_q));
  a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(en_q));
  a_r8_gpe_sci: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q[1] && en_q[1]) || (sts_q[2] && en_q[2])) |-> sci);
  a_r9_pwrbtn_sci: assert property (@(posedge clk) disable iff (!rst_n)
    (pm1_sts[8] && pm1_en[8]) |-> sci);
  a_r10_tmr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pm1_sts[0] |-> !tmr_arm);
endmodule

bind gpe_sci_regs gpe_sci_regs_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .pci_hp_evt(pci_hp_evt), .cpu_hp_evt(cpu_hp_evt), .pm1_sts(pm1_sts),
  .pm1_en(pm1_en), .sci(sci), .tmr_arm(tmr_arm), .sts_q(sts_q), .en_q(en_q)
);

// File: tb/gpe_sci_regs_test.sv
module gpe_sci_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_addr = 0, req_len = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] req_rdata;
  logic        pci_hp_evt = 0, cpu_hp_evt = 0;
  logic [15:0] pm1_sts = 0, pm1_en = 0;
  logic        sci, tmr_arm;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_sts [2];
  logic [7:0] m_en  [2];
  localparam logic [15:0] PM1_MASK = 16'h0521;

  always #4 clk = ~clk;

  gpe_sci_regs uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(int a0, int len);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int a = a0 + k;
      if (k <= len && a < 4) r[k*8 +: 8] = (a < 2) ? m_sts[a] : m_en[a-2];
    end
    return r;
  endfunction

  task automatic wr(int a0, int len, logic [31:0] d, bit pci, bit cpu);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 2'(a0); req_len = 2'(len);
    req_wdata = d; pci_hp_evt = pci; cpu_hp_evt = cpu;
    @(negedge clk);
    req_valid = 0; req_write = 0; pci_hp_evt = 0; cpu_hp_evt = 0;
    for (int k = 0; k < 4; k++) begin
      int a = a0 + k;
      if (k <= len && a < 2) m_sts[a] = m_sts[a] & ~d[k*8 +: 8];
      else if (k <= len && a < 4) m_en[a-2] = d[k*8 +: 8];
    end
    if (pci) m_sts[0][1] = 1'b1;
    if (cpu) m_sts[0][2] = 1'b1;
  endtask

  task automatic evt(bit pci, bit cpu);
    @(negedge clk);
    pci_hp_evt = pci; cpu_hp_evt = cpu;
    @(negedge clk);
    pci_hp_evt = 0; cpu_hp_evt = 0;
    if (pci) m_sts[0][1] = 1'b1;
    if (cpu) m_sts[0][2] = 1'b1;
  endtask

  task automatic rd_check(string req, int a0, int len);
    req_valid = 1; req_write = 0; req_addr = 2'(a0); req_len = 2'(len);
    #1;
    check(req, req_rdata, model_rd(a0, len));
    req_valid = 0;
    #1;
  endtask

  task automatic clear_model();
    m_sts[0] = 0; m_sts[1] = 0; m_en[0] = 0; m_en[1] = 0;
  endtask

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    check("R1 sci after reset", 32'(sci), 0);
    rd_check("R1 window after reset", 0, 3);
    rst_n = 1;
    @(negedge clk);

    // R6 enable bytes read/write, exhaustive on both bytes
    for (int v = 0; v < 256; v++) begin
      wr(2, 0, 32'(v), 0, 0);
      rd_check("R6 enable0 rw", 2, 0);
      wr(3, 0, 32'(255 - v), 0, 0);
      rd_check("R6 enable1 rw", 3, 0);
      check("R8 no status no sci", 32'(sci), 0);
    end

    // R4 event pulses
    evt(1, 0);
    rd_check("R4 pci sets bit1", 0, 1);
    evt(0, 1);
    rd_check("R4 cpu sets bit2", 0, 1);

    // R8 GPE SCI sweep over status patterns and all enable0 values
    for (int s = 0; s < 4; s++) begin
      wr(0, 1, 32'h0000_FFFF, 0, 0);
      evt(s[0], s[1]);
      for (int v = 0; v < 256; v++) begin
        wr(2, 0, 32'(v), 0, 0);
        check("R8 gpe sci", 32'(sci), 32'(|(8'(v) & m_sts[0] & 8'h06)));
      end
    end

    // R5 write-one-to-clear
    wr(0, 1, 32'h0000_FFFF, 0, 0);
    evt(1, 1);
    wr(0, 0, 32'h0000_0002, 0, 0);
    rd_check("R5 clear only bit1", 0, 0);
    check("R5 model bit", 32'(m_sts[0]), 32'h04);
    wr(0, 0, 32'h0000_0000, 0, 0);
    rd_check("R5 zero write keeps", 0, 0);

    // R7 set wins over clear
    wr(0, 0, 32'h0000_0006, 1, 0);
    rd_check("R7 pci set wins", 0, 0);
    check("R7 expected byte", 32'(m_sts[0]), 32'h02);
    wr(0, 0, 32'h0000_0006, 0, 1);
    rd_check("R7 cpu set wins", 0, 0);

    // R2/R3 every address/length for writes and reads
    for (int a = 0; a < 4; a++)
      for (int l = 0; l < 4; l++) begin
        evt(a[0], a[1] ^ l[0]);
        wr(a, l, 32'h1357_9BDF ^ (32'(a * 4 + l) * 32'h0101_0101), 0, 0);
        rd_check("R3 full window after write", 0, 3);
        for (int ra = 0; ra < 4; ra++)
          for (int rl = 0; rl < 4; rl++)
            rd_check("R2 lane map read", ra, rl);
      end

    // R9 PM1 SCI: every status bit against every enable bit, GPE side quiet
    wr(0, 3, 32'h0000_FFFF, 0, 0);
    for (int b = 0; b < 16; b++)
      for (int c = 0; c < 16; c++) begin
        pm1_sts = 16'(1) << b; pm1_en = 16'(1) << c;
        #1;
        check("R9 pm1 sci", 32'(sci), 32'((b == c) && PM1_MASK[b]));
        #1;
      end

    // R10 timer arm
    for (int p = 0; p < 16; p++) begin
      pm1_sts = {15'h2AAA ^ 15'(p * 331), p[0]};
      pm1_en  = {15'h1555 ^ 15'(p * 97),  p[1]};
      #1;
      check("R10 tmr arm", 32'(tmr_arm), 32'(p[1] && !p[0]));
      #1;
    end
    pm1_sts = 0; pm1_en = 0;

    // R1 reset mid-run
    evt(1, 1);
    wr(2, 1, 32'h0000_FFFF, 0, 0);
    check("R1 sci before reset", 32'(sci), 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    clear_model();
    rd_check("R1 window after reset", 0, 3);
    check("R1 sci after reset", 32'(sci), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule